// File: doc/BRIEF.md
# Register-Offset Word Load Execution Unit

This unit carries out one word load whose address is a base register combined with a shifted index register. The caller presents an instruction word together with a form selector: a 32-bit wide form, a 16-bit narrow form, or a 32-bit compact form. The unit decodes the fields and drives the register numbers to a register-file read port. It forms the offset and the effective address, issues one 4-byte read over a valid/ready handshake, and then retires the load.

Retiring produces a destination register write, an optional base writeback, or a branch request to the loaded word when the destination is register 15. Encodings that belong to a different load instruction are reported on a redirect code and are not executed. Unpredictable encodings raise a flag, and a flagged or redirected instruction makes no write of any kind. Only one instruction is in flight at a time.

The unit passes through four states: IDLE, ADDR (operands read, address formed), MEM (read outstanding) and WB (retire). Condition evaluation, the register file, memory and exception entry sit outside the unit.

Top module: `rload_unit`

## Requirements
- R1: A `start` pulse is accepted only in IDLE. One cycle later the unit drives the register read port, and `done` is high for exactly one cycle per accepted instruction. A `start` that arrives while an instruction is in flight is ignored.
- R2: In the wide form (`form`=0), bit 24 selects pre-index (address = base±offset) or post-index (address = base). Bit 23 selects add (1) or subtract (0). The base number is in bits 19:16, the destination in 15:12 and the index in 3:0.
- R3: In the wide form the offset is the index shifted by a type in bits 6:5 and an amount in bits 11:7. The types are 0=LSL, 1=LSR, 2=ASR and 3=ROR. An amount of 0 means 32 for LSR and ASR, and ROR with amount 0 is a one-bit rotate right through `carry_in`.
- R4: In the wide form the base is written back when bit 24 is 0 or bit 21 is 1. The value written is base±offset, in post-index mode too.
- R5: The narrow form (`form`=1) uses bits 15:9 = 0101100, with index, base and destination in bits 8:6, 5:3 and 2:0. It adds the unshifted index, is pre-indexed and never writes back.
- R6: The compact form (`form`=2) has the pattern 111110000101 in bits 31:20, with base in 19:16, destination in 15:12, zeros in 11:6, shift amount in 5:4 and index in 3:0. It adds the index shifted left by 0 to 3 and never writes back.
- R7: The redirect code is 1 for a wide word with bit 24 = 0 and bit 21 = 1, and 2 for a compact word with base 15. Otherwise it is 0. A redirected instruction issues no memory read, makes no write and does not raise `unpred`.
- R8: `unpred` is raised with `done` in these cases: an index of 15; a wide writeback whose base is 15 or equals the destination; a compact destination of 15 while `cond_nonlast` is high; a wide condition field of 1111; or `form`=3. A flagged instruction makes no register, writeback or branch output.
- R9: A destination of 15 gives `br_valid` with the loaded word as `br_target` when address bits 1:0 are 00. With any other address it raises `unpred` and issues no memory read. Other destinations give `rd_we` with the loaded word.
- R10: `mem_rd_valid` stays high with a stable `mem_rd_addr` until `mem_rd_ready` is seen. `mem_rd_data` is taken in the cycle `mem_rd_ready` is high.
- R11: `rd_we`, `wb_we` and `br_valid` are high only in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Instruction inputs valid |
| form | input | 2 | 0 wide, 1 narrow (bits 15:0), 2 compact, 3 reserved |
| insn | input | 32 | Instruction word |
| cond_nonlast | input | 1 | Inside a conditional block and not its last slot |
| rf_base_sel | output | 4 | Base register number for the read port |
| rf_idx_sel | output | 4 | Index register number for the read port |
| rf_base_data | input | 32 | Base register value |
| rf_idx_data | input | 32 | Index register value |
| carry_in | input | 1 | Carry flag for the rotate-through-carry shift |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_addr | output | 32 | Read address |
| mem_rd_ready | input | 1 | Read accepted; data valid |
| mem_rd_data | input | 32 | Read data |
| done | output | 1 | Retire pulse |
| unpred | output | 1 | Unpredictable encoding flag |
| redirect | output | 2 | 0 none, 1 unprivileged-load variant, 2 literal form |
| rd_we | output | 1 | Destination write enable |
| rd_sel | output | 4 | Destination register number |
| rd_data | output | 32 | Loaded word |
| wb_we | output | 1 | Base writeback enable |
| wb_sel | output | 4 | Base register number |
| wb_data | output | 32 | Writeback value |
| br_valid | output | 1 | Branch to loaded word request |
| br_target | output | 32 | Branch target (loaded word) |

## Verification
The assertions check on every cycle that retire is a single pulse and that writes occur only with it. They also check that flagged or redirected instructions write nothing, that a pending read holds its address, that a branch comes only from a word-aligned address, and that narrow and compact forms never write back. The address arithmetic needs the bench's scenarios to show it: the shift types with their zero-amount cases, subtract and post-index addressing, the writeback value and the exact decoding of each unpredictable and redirect case. The bench also shows that a start is ignored while busy.

// File: rtl/rload_pkg.sv
package rload_pkg;
  localparam int XLEN = 32;
  localparam int REGW = 4;
  localparam int AMTW = $clog2(XLEN) + 1;
  localparam logic [REGW-1:0] REG_PC = '1;

  typedef enum logic [1:0] {FORM_WIDE, FORM_NARROW, FORM_COMPACT, FORM_RSVD} form_e;
  typedef enum logic [2:0] {SH_LSL, SH_LSR, SH_ASR, SH_ROR, SH_RRX} shkind_e;
  typedef enum logic [1:0] {RD_NONE, RD_UNPRIV, RD_LITERAL} redir_e;

  typedef struct packed {
    logic [REGW-1:0] dest;
    logic [REGW-1:0] base;
    logic [REGW-1:0] idx;
    shkind_e         kind;
    logic [AMTW-1:0] amt;
    logic            pre;
    logic            add;
    logic            wback;
    redir_e          redir;
    logic            bad;
  } dec_t;

  function automatic logic [XLEN-1:0] shift_apply(input logic [XLEN-1:0] v,
                                                  input shkind_e k,
                                                  input logic [AMTW-1:0] a,
                                                  input logic cin);
    logic [AMTW-2:0] r;
    r = a[AMTW-2:0];
    case (k)
      SH_LSL:  shift_apply = v << a;
      SH_LSR:  shift_apply = v >> a;
      SH_ASR:  shift_apply = $unsigned($signed(v) >>> a);
      SH_ROR:  shift_apply = (r == '0) ? v : ((v >> r) | (v << (AMTW'(XLEN) - {1'b0, r})));
      default: shift_apply = {cin, v[XLEN-1:1]};
    endcase
  endfunction

  function automatic logic [XLEN-1:0] offset_combine(input logic [XLEN-1:0] b,
                                                     input logic [XLEN-1:0] o,
                                                     input logic add);
    offset_combine = add ? (b + o) : (b - o);
  endfunction
endpackage

// File: rtl/rload_decode.sv
module rload_decode
  import rload_pkg::*;
(
  input  form_e           form,
  input  logic [XLEN-1:0] insn,
  input  logic            cond_nonlast,
  output dec_t            dec
);
  logic [4:0] imm5;
  logic [1:0] stype;
  assign imm5  = insn[11:7];
  assign stype = insn[6:5];

  always_comb begin
    dec = '0;
    dec.kind  = SH_LSL;
    dec.redir = RD_NONE;
    case (form)
      FORM_WIDE: begin
        dec.base  = insn[19:16];
        dec.dest  = insn[15:12];
        dec.idx   = insn[3:0];
        dec.pre   = insn[24];
        dec.add   = insn[23];
        dec.wback = !insn[24] || insn[21];
        case (stype)
          2'd0: begin dec.kind = SH_LSL; dec.amt = {1'b0, imm5}; end
          2'd1: begin dec.kind = SH_LSR; dec.amt = (imm5 == '0) ? AMTW'(XLEN) : {1'b0, imm5}; end
          2'd2: begin dec.kind = SH_ASR; dec.amt = (imm5 == '0) ? AMTW'(XLEN) : {1'b0, imm5}; end
          default: begin dec.kind = (imm5 == '0) ? SH_RRX : SH_ROR; dec.amt = {1'b0, imm5}; end
        endcase
        if (!insn[24] && insn[21]) dec.redir = RD_UNPRIV;
        dec.bad = (insn[31:28] == 4'hF) || (insn[27:25] != 3'b011) || insn[22]
               || !insn[20] || insn[4] || (dec.idx == REG_PC)
               || (dec.wback && ((dec.base == REG_PC) || (dec.base == dec.dest)));
      end
      FORM_NARROW: begin
        dec.idx  = {1'b0, insn[8:6]};
        dec.base = {1'b0, insn[5:3]};
        dec.dest = {1'b0, insn[2:0]};
        dec.pre  = 1'b1;
        dec.add  = 1'b1;
        dec.bad  = (insn[15:9] != 7'b0101100);
      end
      FORM_COMPACT: begin
        dec.base = insn[19:16];
        dec.dest = insn[15:12];
        dec.idx  = insn[3:0];
        dec.amt  = {{(AMTW-2){1'b0}}, insn[5:4]};
        dec.pre  = 1'b1;
        dec.add  = 1'b1;
        if (dec.base == REG_PC) dec.redir = RD_LITERAL;
        dec.bad = (insn[31:20] != 12'b1111_1000_0101) || (insn[11:6] != '0)
               || (dec.idx == REG_PC) || ((dec.dest == REG_PC) && cond_nonlast);
      end
      default: dec.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/rload_agen.sv
module rload_agen
  import rload_pkg::*;
(
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] idx_val,
  input  logic            cin,
  input  shkind_e         kind,
  input  logic [AMTW-1:0] amt,
  input  logic            pre,
  input  logic            add,
  output logic [XLEN-1:0] offset_addr,
  output logic [XLEN-1:0] eff_addr
);
  logic [XLEN-1:0] offset;
  assign offset      = shift_apply(idx_val, kind, amt, cin);
  assign offset_addr = offset_combine(base_val, offset, add);
  assign eff_addr    = pre ? offset_addr : base_val;
endmodule

// File: rtl/rload_unit.sv
module rload_unit
  import rload_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       form,
  input  logic [XLEN-1:0]  insn,
  input  logic             cond_nonlast,
  output logic [REGW-1:0]  rf_base_sel,
  output logic [REGW-1:0]  rf_idx_sel,
  input  logic [XLEN-1:0]  rf_base_data,
  input  logic [XLEN-1:0]  rf_idx_data,
  input  logic             carry_in,
  output logic             mem_rd_valid,
  output logic [XLEN-1:0]  mem_rd_addr,
  input  logic             mem_rd_ready,
  input  logic [XLEN-1:0]  mem_rd_data,
  output logic             done,
  output logic             unpred,
  output logic [1:0]       redirect,
  output logic             rd_we,
  output logic [REGW-1:0]  rd_sel,
  output logic [XLEN-1:0]  rd_data,
  output logic             wb_we,
  output logic [REGW-1:0]  wb_sel,
  output logic [XLEN-1:0]  wb_data,
  output logic             br_valid,
  output logic [XLEN-1:0]  br_target
);
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_MEM, ST_WB} st_e;
  st_e st;

  logic [XLEN-1:0] insn_q, addr_q, wbval_q, data_q;
  form_e           form_q;
  logic            cnl_q, unp_q;
  redir_e          redir_q;
  dec_t            d;
  logic [XLEN-1:0] off_addr, eff_addr;

  rload_decode u_dec (.form(form_q), .insn(insn_q), .cond_nonlast(cnl_q), .dec(d));

  rload_agen u_agen (
    .base_val(rf_base_data), .idx_val(rf_idx_data), .cin(carry_in),
    .kind(d.kind), .amt(d.amt), .pre(d.pre), .add(d.add),
    .offset_addr(off_addr), .eff_addr(eff_addr)
  );

  // Named internal events for the checker
  logic addr_phase, mem_phase, retire, mem_fire, pc_misalign, unp_now, ok_retire;
  assign addr_phase  = (st == ST_ADDR);
  assign mem_phase   = (st == ST_MEM);
  assign retire      = (st == ST_WB);
  assign mem_fire    = mem_phase && mem_rd_ready;
  assign pc_misalign = (d.dest == REG_PC) && (eff_addr[1:0] != 2'b00);
  assign unp_now     = (d.redir == RD_NONE) && (d.bad || pc_misalign);
  assign ok_retire   = retire && !unp_q && (redir_q == RD_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      insn_q  <= '0;
      form_q  <= FORM_WIDE;
      cnl_q   <= 1'b0;
      addr_q  <= '0;
      wbval_q <= '0;
      data_q  <= '0;
      unp_q   <= 1'b0;
      redir_q <= RD_NONE;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          insn_q <= insn;
          form_q <= form_e'(form);
          cnl_q  <= cond_nonlast;
          st     <= ST_ADDR;
        end
        ST_ADDR: begin
          addr_q  <= eff_addr;
          wbval_q <= off_addr;
          unp_q   <= unp_now;
          redir_q <= d.redir;
          st      <= (unp_now || (d.redir != RD_NONE)) ? ST_WB : ST_MEM;
        end
        ST_MEM: if (mem_rd_ready) begin
          data_q <= mem_rd_data;
          st     <= ST_WB;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign rf_base_sel  = d.base;
  assign rf_idx_sel   = d.idx;
  assign mem_rd_valid = mem_phase;
  assign mem_rd_addr  = addr_q;
  assign done         = retire;
  assign unpred       = retire && unp_q;
  assign redirect     = retire ? redir_q : RD_NONE;
  assign rd_we        = ok_retire && (d.dest != REG_PC);
  assign rd_sel       = d.dest;
  assign rd_data      = data_q;
  assign br_valid     = ok_retire && (d.dest == REG_PC);
  assign br_target    = data_q;
  assign wb_we        = ok_retire && d.wback;
  assign wb_sel       = d.base;
  assign wb_data      = wbval_q;
endmodule

// File: rtl/rload_checker.sv
module rload_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        unpred,
  input logic [1:0]  redirect,
  input logic        rd_we,
  input logic        wb_we,
  input logic        br_valid,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [31:0] mem_rd_addr,
  input logic        addr_phase,
  input logic [31:0] addr_q,
  input logic [1:0]  form_q
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R1
  AST_ADDR_AFTER_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) addr_phase |=> !addr_phase); // R1
  AST_FLAG_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (unpred || (redirect != 2'd0)) |-> !(rd_we || wb_we || br_valid)); // R8
  AST_REDIRECT_NOT_UNPRED: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect != 2'd0) |-> !unpred); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R10
  AST_BR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |-> (addr_q[1:0] == 2'b00)); // R9
  AST_WRITE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_we || wb_we || br_valid) |-> done); // R11
  AST_ONE_RESULT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_we && br_valid)); // R9
  AST_NO_WB_SHORT_FORMS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (form_q != 2'd0)) |-> !wb_we); // R5 R6
endmodule

bind rload_unit rload_checker u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .unpred(unpred), .redirect(redirect),
  .rd_we(rd_we), .wb_we(wb_we), .br_valid(br_valid), .mem_rd_valid(mem_rd_valid),
  .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr), .addr_phase(addr_phase),
  .addr_q(addr_q), .form_q(form_q)
);

// File: tb/tb_rload_unit.sv
`timescale 1ns/1ps
module tb_rload_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] form = 2'd0;
  logic [31:0] insn = '0;
  logic cond_nonlast = 1'b0;
  logic [3:0] rf_base_sel, rf_idx_sel;
  logic [31:0] rf_base_data, rf_idx_data;
  logic carry_in = 1'b0;
  logic mem_rd_valid;
  logic [31:0] mem_rd_addr;
  logic mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic done, unpred, rd_we, wb_we, br_valid;
  logic [1:0] redirect;
  logic [3:0] rd_sel, wb_sel;
  logic [31:0] rd_data, wb_data, br_target;

  logic [31:0] regs [16];
  assign rf_base_data = regs[rf_base_sel];
  assign rf_idx_data  = regs[rf_idx_sel];

  rload_unit dut (.*);

  always #2 clk = ~clk;

  int nvec = 0, nfail = 0, cycles = 0;
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] memf(input logic [31:0] a);
    memf = {a[15:0], ~a[31:16]} ^ 32'h5a3c_0f96;
  endfunction

  // Independent shift model using widened operands
  function automatic logic [31:0] ref_shift(input logic [31:0] v, input int typ, input int amt, input logic c);
    logic [63:0] w;
    case (typ)
      0: begin w = {32'b0, v} << amt; ref_shift = w[31:0]; end
      1: begin w = {32'b0, v} >> amt; ref_shift = w[31:0]; end
      2: begin w = {{32{v[31]}}, v} >> amt; ref_shift = w[31:0]; end
      3: begin w = {v, v} >> amt; ref_shift = w[31:0]; end
      default: ref_shift = {c, v[31:1]};
    endcase
  endfunction

  function automatic logic [31:0] enc_wide(input logic [3:0] cnd, input logic p, u, w,
      input logic [3:0] bn, dn, input logic [4:0] i5, input logic [1:0] st, input logic [3:0] xn);
    enc_wide = {cnd, 3'b011, p, u, 1'b0, w, 1'b1, bn, dn, i5, st, 1'b0, xn};
  endfunction
  function automatic logic [31:0] enc_narrow(input logic [2:0] xn, bn, dn);
    enc_narrow = {16'h0, 7'b0101100, xn, bn, dn};
  endfunction
  function automatic logic [31:0] enc_compact(input logic [3:0] bn, dn, input logic [1:0] sh, input logic [3:0] xn);
    enc_compact = {12'b1111_1000_0101, bn, dn, 6'b0, sh, xn};
  endfunction

  // expected values
  logic e_unp, e_rdwe, e_wbwe, e_br, e_mem;
  logic [1:0] e_redir;
  logic [3:0] e_rdsel, e_wbsel;
  logic [31:0] e_addr, e_data, e_wbdata;

  task automatic model(input logic [1:0] f, input logic [31:0] w, input logic cnl);
    int b, d, x, typ, amt;
    logic pre, add, wbk, bad;
    logic [31:0] off, oa;
    e_redir = 2'd0; bad = 1'b0; wbk = 1'b0; pre = 1'b1; add = 1'b1; typ = 0; amt = 0;
    b = 0; d = 0; x = 0;
    if (f == 2'd0) begin
      b = w[19:16]; d = w[15:12]; x = w[3:0];
      pre = w[24]; add = w[23]; wbk = (w[24] == 1'b0) || w[21];
      typ = w[6:5]; amt = w[11:7];
      if ((typ == 1 || typ == 2) && amt == 0) amt = 32;
      if (typ == 3 && amt == 0) typ = 4;
      if (!w[24] && w[21]) e_redir = 2'd1;
      bad = (w[31:28] == 4'hF) || x == 15 || (wbk && (b == 15 || b == d));
    end else if (f == 2'd1) begin
      x = w[8:6]; b = w[5:3]; d = w[2:0];
    end else if (f == 2'd2) begin
      b = w[19:16]; d = w[15:12]; x = w[3:0]; amt = w[5:4];
      if (b == 15) e_redir = 2'd2;
      bad = x == 15 || (d == 15 && cnl);
    end else bad = 1'b1;
    off = ref_shift(regs[x], typ, amt, carry_in);
    oa = add ? regs[b] + off : regs[b] - off;
    e_addr = pre ? oa : regs[b];
    if (d == 15 && e_addr[1:0] != 2'b00) bad = 1'b1;
    e_unp = (e_redir == 2'd0) && bad;
    e_mem = (e_redir == 2'd0) && !e_unp;
    e_data = memf(e_addr);
    e_rdwe = e_mem && d != 15; e_rdsel = 4'(d);
    e_br = e_mem && d == 15;
    e_wbwe = e_mem && wbk; e_wbsel = 4'(b); e_wbdata = oa;
  endtask

  task automatic run_case(input string tag, input logic [1:0] f, input logic [31:0] w,
                          input logic cnl, input int delay, input bit inject);
    int waitc, ncyc;
    bit seen_mem, got;
    logic [31:0] a0;
    model(f, w, cnl);
    @(negedge clk);
    start = 1'b1; form = f; insn = w; cond_nonlast = cnl;
    @(negedge clk);
    start = 1'b0; insn = 32'hdead_beef;
    waitc = 0; seen_mem = 0; got = 0; a0 = '0; ncyc = 0;
    while (!got && ncyc < 64) begin
      @(negedge clk);
      ncyc++;
      start = 1'b0;
      if (done) begin
        got = 1;
        mem_rd_ready = 1'b0;
        chk({tag, " R7 redirect"}, {30'b0, redirect}, {30'b0, e_redir});
        chk({tag, " R8 unpred"}, {31'b0, unpred}, {31'b0, e_unp});
        chk({tag, " R9 rd_we"}, {31'b0, rd_we}, {31'b0, e_rdwe});
        chk({tag, " R9 br_valid"}, {31'b0, br_valid}, {31'b0, e_br});
        chk({tag, " R4 wb_we"}, {31'b0, wb_we}, {31'b0, e_wbwe});
        if (e_rdwe) begin
          chk({tag, " R2 rd_sel"}, {28'b0, rd_sel}, {28'b0, e_rdsel});
          chk({tag, " R10 rd_data"}, rd_data, e_data);
        end
        if (e_br) chk({tag, " R9 br_target"}, br_target, e_data);
        if (e_wbwe) begin
          chk({tag, " R4 wb_sel"}, {28'b0, wb_sel}, {28'b0, e_wbsel});
          chk({tag, " R4 wb_data"}, wb_data, e_wbdata);
        end
        chk({tag, " R7 memory read issued"}, {31'b0, seen_mem}, {31'b0, e_mem});
      end else if (mem_rd_valid) begin
        if (!seen_mem) begin
          seen_mem = 1; a0 = mem_rd_addr;
          chk({tag, " R2 address"}, mem_rd_addr, e_addr);
          if (inject) begin start = 1'b1; insn = enc_narrow(3'd1, 3'd2, 3'd3); form = 2'd1; end
        end else chk({tag, " R10 address held"}, mem_rd_addr, a0);
        mem_rd_ready = (waitc == delay);
        mem_rd_data = (waitc == delay) ? memf(mem_rd_addr) : 32'h0bad_0bad;
        waitc++;
      end else if (rd_we || wb_we || br_valid) begin
        chk({tag, " R11 write outside done"}, 32'd1, 32'd0);
      end
    end
    chk({tag, " R1 done seen"}, {31'b0, got}, 32'd1);
    @(negedge clk);
    chk({tag, " R1 done single"}, {31'b0, done}, 32'd0);
    if (inject) begin
      repeat (4) begin
        @(negedge clk);
        chk({tag, " R1 busy start ignored"}, {31'b0, done | mem_rd_valid}, 32'd0);
      end
    end
  endtask

  task automatic fill_regs();
    for (int i = 0; i < 16; i++) regs[i] = $urandom;
  endtask

  task automatic t_reset();
    chk("R1 reset done", {31'b0, done}, 32'd0);
    chk("R10 reset mem_rd_valid", {31'b0, mem_rd_valid}, 32'd0);
    chk("R11 reset writes", {29'b0, rd_we, wb_we, br_valid}, 32'd0);
  endtask

  task automatic t_wide_modes();
    fill_regs();
    run_case("R2 pre add lsl", 2'd0, enc_wide(4'hE, 1, 1, 0, 4'd2, 4'd3, 5'd4, 2'd0, 4'd5), 0, 0, 0);
    run_case("R2 pre sub", 2'd0, enc_wide(4'h0, 1, 0, 0, 4'd1, 4'd7, 5'd0, 2'd0, 4'd8), 0, 2, 0);
    run_case("R4 post sub writeback", 2'd0, enc_wide(4'hE, 0, 0, 0, 4'd4, 4'd6, 5'd3, 2'd0, 4'd2), 0, 1, 0);
    run_case("R4 pre add writeback", 2'd0, enc_wide(4'hE, 1, 1, 1, 4'd9, 4'd1, 5'd1, 2'd1, 4'd3), 0, 0, 0);
  endtask

  task automatic t_shifts();
    fill_regs();
    regs[5] = 32'h8000_1235;
    run_case("R3 lsr 32", 2'd0, enc_wide(4'hE, 1, 1, 0, 4'd2, 4'd3, 5'd0, 2'd1, 4'd5), 0, 0, 0);
    run_case("R3 asr 32 negative", 2'd0, enc_wide(4'hE, 1, 1, 0, 4'd2, 4'd3, 5'd0, 2'd2, 4'd5), 0, 0, 0);
    run_case("R3 asr 7", 2'd0, enc_wide(4'hE, 1, 0, 0, 4'd2, 4'd3, 5'd7, 2'd2, 4'd5), 0, 0, 0);
    run_case("R3 ror 9", 2'd0, enc_wide(4'hE, 1, 1, 0, 4'd2, 4'd3, 5'd9, 2'd3, 4'd5), 0, 0, 0);
    carry_in = 1'b1;
    run_case("R3 rrx carry 1", 2'd0, enc_wide(4'hE, 1, 1, 0, 4'd2, 4'd3, 5'd0, 2'd3, 4'd5), 0, 0, 0);
    carry_in = 1'b0;
    run_case("R3 rrx carry 0", 2'd0, enc_wide(4'hE, 1, 1, 0, 4'd2, 4'd3, 5'd0, 2'd3, 4'd5), 0, 0, 0);
  endtask

  task automatic t_narrow();
    fill_regs();
    run_case("R5 narrow", 2'd1, enc_narrow(3'd6, 3'd1, 3'd4), 0, 0, 0);
    run_case("R5 narrow same base dest", 2'd1, enc_narrow(3'd0, 3'd7, 3'd7), 0, 3, 0);
  endtask

  task automatic t_compact();
    fill_regs();
    for (int s = 0; s < 4; s++)
      run_case("R6 compact lsl imm2", 2'd2, enc_compact(4'd3, 4'd10, 2'(s), 4'd11), 0, s, 0);
  endtask

  task automatic t_redirects();
    fill_regs();
    run_case("R7 wide unpriv variant", 2'd0, enc_wide(4'hE, 0, 1, 1, 4'd2, 4'd3, 5'd0, 2'd0, 4'd5), 0, 0, 0);
    run_case("R7 compact literal", 2'd2, enc_compact(4'd15, 4'd2, 2'd1, 4'd3), 0, 0, 0);
  endtask

  task automatic t_unpred();
    fill_regs();
    run_case("R8 index 15", 2'd0, enc_wide(4'hE, 1, 1, 0, 4'd2, 4'd3, 5'd0, 2'd0, 4'd15), 0, 0, 0);
    run_case("R8 wb base 15", 2'd0, enc_wide(4'hE, 1, 1, 1, 4'd15, 4'd3, 5'd0, 2'd0, 4'd5), 0, 0, 0);
    run_case("R8 wb base eq dest", 2'd0, enc_wide(4'hE, 0, 1, 0, 4'd6, 4'd6, 5'd0, 2'd0, 4'd5), 0, 0, 0);
    regs[1] = 32'h100; regs[2] = 32'h40;
    run_case("R8 compact pc dest cond nonlast", 2'd2, enc_compact(4'd1, 4'd15, 2'd0, 4'd2), 1, 0, 0);
    run_case("R8 wide cond 1111", 2'd0, enc_wide(4'hF, 1, 1, 0, 4'd2, 4'd3, 5'd0, 2'd0, 4'd5), 0, 0, 0);
    run_case("R8 reserved form", 2'd3, 32'h0, 0, 0, 0);
  endtask

  task automatic t_pc_dest();
    fill_regs();
    regs[1] = 32'h2000_0100; regs[2] = 32'h10;
    run_case("R9 pc aligned compact last slot", 2'd2, enc_compact(4'd1, 4'd15, 2'd2, 4'd2), 0, 1, 0);
    run_case("R9 pc aligned wide", 2'd0, enc_wide(4'hE, 1, 1, 0, 4'd1, 4'd15, 5'd2, 2'd0, 4'd2), 0, 0, 0);
    regs[2] = 32'h11;
    run_case("R9 pc misaligned", 2'd0, enc_wide(4'hE, 1, 1, 0, 4'd1, 4'd15, 5'd0, 2'd0, 4'd2), 0, 0, 0);
  endtask

  task automatic t_handshake_busy();
    fill_regs();
    run_case("R10 long wait", 2'd0, enc_wide(4'hE, 1, 0, 0, 4'd4, 4'd5, 5'd2, 2'd0, 4'd6), 0, 9, 0);
    run_case("R1 start while busy", 2'd2, enc_compact(4'd4, 4'd5, 2'd1, 4'd6), 0, 3, 1);
  endtask

  task automatic t_random();
    for (int n = 0; n < 60; n++) begin
      logic [3:0] cnd;
      fill_regs();
      carry_in = $urandom_range(0, 1);
      cnd = 4'($urandom_range(0, 14));
      run_case("R2 R3 R4 random wide", 2'd0,
               enc_wide(cnd, 1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), 4'($urandom),
                        5'($urandom), 2'($urandom), 4'($urandom)), 0, $urandom_range(0, 3), 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_wide_modes();
    t_shifts();
    t_narrow();
    t_compact();
    t_redirects();
    t_unpred();
    t_pc_dest();
    t_handshake_busy();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule